// File: doc/BRIEF.md
# DRAM Refresh and Initialization Sequencer

This block produces every refresh cycle needed by an asynchronous EDO DRAM with an 11-bit multiplexed address. After reset it counts out a power-up delay. It then runs a fixed number of initialization refresh cycles on its own, and only after those does it signal that the memory is ready. From then on an internal interval timer posts one refresh request per period. The requests are held in a saturating pending counter, so refreshes that wait for a grant are not lost.

The block does not arbitrate against host traffic. It raises `ref_req`, and an external memory controller answers with `ref_gnt`. On a grant the block takes the strobes (`strobe_own` high) and drives RAS, CAS and WE through one refresh cycle, then pulses `ref_done`. The default cycle is CAS-before-RAS, with WE held high so that the device cannot enter its test mode. A parameter selects RAS-only refresh instead. In that mode an internal row counter supplies the address. Every duration is given in nanoseconds and rounded up to whole clock cycles using the clock period parameter.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is asserted, `ras_n`, `cas_n` and `we_n` are 1, and `ref_req`, `ref_done`, `init_done` and `strobe_own` are 0.
- R2: For the first ceil(POWERUP_NS / clock period) cycles after reset is released, no strobe goes low, `strobe_own` stays 0 and `init_done` stays 0.
- R3: After the power-up wait, exactly INIT_CYCLES refresh cycles run without any grant. `init_done` rises at the end of the last one. `ref_req` is 0 while `init_done` is 0.
- R4: Once `init_done` is 1, a refresh becomes pending every ceil(INTERVAL_NS / clock period) cycles. The first one shows on `ref_req` that many cycles after `init_done` rises.
- R5: In CAS-before-RAS mode, `cas_n` falls ceil(T_CSR_NS) cycles (at least 1) before `ras_n` falls. It stays low for ceil(T_CHR_NS) cycles after the RAS fall. `we_n` is 1 throughout.
- R6: `ras_n` stays low for max(ceil(T_RAS_NS), hold time) cycles. It then stays high for at least max(ceil(T_RP_NS), ceil(T_RPC_NS)) cycles before it falls again.
- R7: A grant while `ref_req` is 1 starts a cycle on the next clock edge. `ref_req` drops while that cycle runs. `ref_done` is a one-cycle pulse in the last precharge cycle of a granted cycle and never follows an initialization cycle.
- R8: Pending refreshes saturate at MAX_PEND. After a long wait without grants, exactly MAX_PEND granted cycles run before `ref_req` falls.
- R9: `ref_gnt` while `ref_req` is 0 has no effect: no strobe moves and `strobe_own` stays 0.
- R10: In RAS-only mode, `cas_n` stays 1. `row_addr` is stable for the whole RAS-low time. `row_addr` advances by one after every cycle, initialization cycles included, starting at 0 and wrapping modulo 2^ROW_W.
- R11: Every duration equals its nanosecond value divided by the clock period, rounded up to a whole cycle.
- R12: When `strobe_own` is 0, all three strobes are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_gnt | input | 1 | Grant from the memory controller |
| ref_req | output | 1 | A refresh is pending and the sequencer is idle |
| ref_done | output | 1 | One-cycle pulse at the end of a granted refresh |
| init_done | output | 1 | Power-up wait and initialization cycles are complete |
| strobe_own | output | 1 | Sequencer is driving the DRAM strobes |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low, held high |
| row_addr | output | ROW_W | Row address for RAS-only refresh, 0 in CAS-before-RAS mode |

## Verification
The assertions assume that the controller raises `ref_gnt` only as an answer to `ref_req`, and that it gives the strobes back to the sequencer after a grant, so every edge on `ras_n` comes from this block. The stimulus keeps to this. Grants are applied either at the cycle `ref_req` is seen, or held high across windows chosen to fall between interval ticks, so the counts of completed cycles can be predicted. The RAS-only instance gets a grant that is held high for the whole run. That instance is checked on each RAS edge for its address sequence and its wrap.

// File: rtl/dram_rf_pkg.sv
package dram_rf_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_LEAD,
    SQ_ACT,
    SQ_PRE
  } seq_state_t;

  typedef enum logic [1:0] {
    PH_PWRUP,
    PH_INIT,
    PH_RUN
  } phase_t;

  // whole clock cycles covering a duration in nanoseconds (rounded up)
  function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                               input int unsigned period_ps);
    return (ns * 1000 + period_ps - 1) / period_ps;
  endfunction

  function automatic int unsigned at_least_one(input int unsigned v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rf_interval.sv
module rf_interval #(
  parameter int unsigned PERIOD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int unsigned CW = $clog2(PERIOD + 1);

  logic [CW-1:0] cnt_q;

  assign tick = en && (cnt_q == CW'(PERIOD - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!en || tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/rf_pending.sv
module rf_pending #(
  parameter int unsigned MAX_PEND = 8,
  parameter int unsigned PEND_W   = $clog2(MAX_PEND + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc,
  input  logic              dec,
  output logic [PEND_W-1:0] count,
  output logic              nonzero
);
  logic [PEND_W-1:0] cnt_q;
  logic              at_max;
  logic              do_inc;
  logic              do_dec;

  assign at_max  = (cnt_q == PEND_W'(MAX_PEND));
  assign nonzero = (cnt_q != '0);
  assign do_inc  = inc && !at_max;
  assign do_dec  = dec && nonzero;
  assign count   = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (do_inc && !do_dec) begin
      cnt_q <= cnt_q + 1'b1;
    end else if (do_dec && !do_inc) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/rf_strobe_fsm.sv
module rf_strobe_fsm
  import dram_rf_pkg::*;
#(
  parameter bit          RAS_ONLY = 1'b0,
  parameter int unsigned L_LEAD   = 1,
  parameter int unsigned L_ACT    = 8,
  parameter int unsigned L_CHR    = 2,
  parameter int unsigned L_PRE    = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic idle,
  output logic done,
  output logic own,
  output logic ras_n,
  output logic cas_n,
  output logic we_n
);
  localparam int unsigned L_MAX = max2(max2(L_LEAD, L_ACT), max2(L_PRE, L_CHR));
  localparam int unsigned CW    = $clog2(L_MAX + 1);

  seq_state_t    st_q;
  logic [CW-1:0] cnt_q;
  logic          phase_end;

  always_comb begin
    case (st_q)
      SQ_LEAD: phase_end = (cnt_q == CW'(L_LEAD - 1));
      SQ_ACT:  phase_end = (cnt_q == CW'(L_ACT - 1));
      SQ_PRE:  phase_end = (cnt_q == CW'(L_PRE - 1));
      default: phase_end = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      cnt_q <= '0;
    end else begin
      case (st_q)
        SQ_IDLE: begin
          cnt_q <= '0;
          if (start) st_q <= SQ_LEAD;
        end
        SQ_LEAD, SQ_ACT, SQ_PRE: begin
          if (phase_end) begin
            cnt_q <= '0;
            case (st_q)
              SQ_LEAD: st_q <= SQ_ACT;
              SQ_ACT:  st_q <= SQ_PRE;
              default: st_q <= SQ_IDLE;
            endcase
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  assign idle  = (st_q == SQ_IDLE);
  assign own   = !idle;
  assign done  = (st_q == SQ_PRE) && phase_end;
  assign ras_n = (st_q != SQ_ACT);
  // WE stays high in every refresh cycle so a CAS-first cycle never starts test mode
  assign we_n  = 1'b1;

  generate
    if (RAS_ONLY) begin : g_ras_only
      assign cas_n = 1'b1;
    end else begin : g_cbr
      assign cas_n = !((st_q == SQ_LEAD) ||
                       ((st_q == SQ_ACT) && (cnt_q < CW'(L_CHR))));
    end
  endgenerate
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dram_rf_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 8000,
  parameter int unsigned ROW_W         = 11,
  parameter bit          RAS_ONLY      = 1'b0,
  parameter int unsigned POWERUP_NS    = 200000,
  parameter int unsigned INIT_CYCLES   = 8,
  parameter int unsigned INTERVAL_NS   = 15600,
  parameter int unsigned MAX_PEND      = 8,
  parameter int unsigned T_CSR_NS      = 5,
  parameter int unsigned T_CHR_NS      = 10,
  parameter int unsigned T_RAS_NS      = 60,
  parameter int unsigned T_RP_NS       = 40,
  parameter int unsigned T_RPC_NS      = 5,
  parameter int unsigned T_ASR_NS      = 0,
  parameter int unsigned T_RAH_NS      = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_gnt,
  output logic             ref_req,
  output logic             ref_done,
  output logic             init_done,
  output logic             strobe_own,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic [ROW_W-1:0] row_addr
);
  // R11: every duration rounded up to whole clock cycles
  localparam int unsigned PU_CYC  = at_least_one(ns_to_cycles(POWERUP_NS, CLK_PERIOD_PS));
  localparam int unsigned IV_CYC  = at_least_one(ns_to_cycles(INTERVAL_NS, CLK_PERIOD_PS));
  localparam int unsigned C_CSR   = at_least_one(ns_to_cycles(T_CSR_NS, CLK_PERIOD_PS));
  localparam int unsigned C_ASR   = at_least_one(ns_to_cycles(T_ASR_NS, CLK_PERIOD_PS));
  localparam int unsigned C_CHR   = at_least_one(ns_to_cycles(T_CHR_NS, CLK_PERIOD_PS));
  localparam int unsigned C_RAH   = at_least_one(ns_to_cycles(T_RAH_NS, CLK_PERIOD_PS));
  localparam int unsigned C_RAS   = at_least_one(ns_to_cycles(T_RAS_NS, CLK_PERIOD_PS));
  localparam int unsigned C_RP    = at_least_one(ns_to_cycles(T_RP_NS, CLK_PERIOD_PS));
  localparam int unsigned C_RPC   = ns_to_cycles(T_RPC_NS, CLK_PERIOD_PS);
  localparam int unsigned L_LEAD  = RAS_ONLY ? C_ASR : C_CSR;
  localparam int unsigned L_ACT   = max2(C_RAS, RAS_ONLY ? C_RAH : C_CHR);
  localparam int unsigned L_PRE   = max2(C_RP, C_RPC);
  localparam int unsigned PEND_W  = $clog2(MAX_PEND + 1);
  localparam int unsigned INIT_W  = $clog2(INIT_CYCLES + 1);

  phase_t             phase_q;
  logic [INIT_W-1:0]  init_cnt_q;
  logic [PEND_W-1:0]  pend_cnt;
  logic               pu_tick;
  logic               iv_tick;
  logic               in_pwrup;
  logic               run;
  logic               seq_idle;
  logic               seq_done;
  logic               seq_start;
  logic               init_start;
  logic               host_start;
  logic               pend_nz;

  assign in_pwrup   = (phase_q == PH_PWRUP);
  assign run        = (phase_q == PH_RUN);
  assign init_start = (phase_q == PH_INIT) && seq_idle;
  assign host_start = run && seq_idle && pend_nz && ref_gnt;
  assign seq_start  = init_start || host_start;

  rf_interval #(.PERIOD(PU_CYC)) u_pwrup_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (in_pwrup),
    .tick (pu_tick)
  );

  rf_interval #(.PERIOD(IV_CYC)) u_refresh_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (run),
    .tick (iv_tick)
  );

  rf_pending #(.MAX_PEND(MAX_PEND), .PEND_W(PEND_W)) u_pending (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc    (iv_tick),
    .dec    (host_start),
    .count  (pend_cnt),
    .nonzero(pend_nz)
  );

  rf_strobe_fsm #(
    .RAS_ONLY(RAS_ONLY),
    .L_LEAD  (L_LEAD),
    .L_ACT   (L_ACT),
    .L_CHR   (C_CHR),
    .L_PRE   (L_PRE)
  ) u_strobes (
    .clk  (clk),
    .rst_n(rst_n),
    .start(seq_start),
    .idle (seq_idle),
    .done (seq_done),
    .own  (strobe_own),
    .ras_n(ras_n),
    .cas_n(cas_n),
    .we_n (we_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= PH_PWRUP;
      init_cnt_q <= '0;
    end else begin
      case (phase_q)
        PH_PWRUP: if (pu_tick) phase_q <= PH_INIT;
        PH_INIT: begin
          if (seq_done) begin
            init_cnt_q <= init_cnt_q + 1'b1;
            if (init_cnt_q == INIT_W'(INIT_CYCLES - 1)) phase_q <= PH_RUN;
          end
        end
        default: phase_q <= PH_RUN;
      endcase
    end
  end

  assign ref_req   = run && seq_idle && pend_nz;
  assign ref_done  = run && seq_done;
  assign init_done = run;

  generate
    if (RAS_ONLY) begin : g_row_counter
      logic [ROW_W-1:0] row_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        row_q <= '0;
        else if (seq_done) row_q <= row_q + 1'b1;
      end
      assign row_addr = row_q;
    end else begin : g_no_row
      assign row_addr = '0;
    end
  endgenerate
endmodule

// File: rtl/dram_refresh_chk.sv
module dram_refresh_chk #(
  parameter bit          RAS_ONLY = 1'b0,
  parameter int unsigned ROW_W    = 11,
  parameter int unsigned PEND_W   = 4,
  parameter int unsigned MAX_PEND = 8,
  parameter int unsigned L_ACT    = 8,
  parameter int unsigned L_PRE    = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ref_gnt,
  input logic             ref_req,
  input logic             ref_done,
  input logic             init_done,
  input logic             strobe_own,
  input logic             ras_n,
  input logic             cas_n,
  input logic             we_n,
  input logic [ROW_W-1:0] row_addr,
  input logic [PEND_W-1:0] pend_cnt
);
  logic [15:0] low_cnt;
  logic [15:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
      hi_cnt  <= '0;
    end else if (!ras_n) begin
      hi_cnt  <= '0;
      if (low_cnt != 16'hFFFF) low_cnt <= low_cnt + 1'b1;
    end else begin
      low_cnt <= '0;
      if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 1'b1;
    end
  end

  assert_req_after_init_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> init_done);

  assert_ras_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (low_cnt == 16'(L_ACT)));

  assert_precharge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (hi_cnt >= 16'(L_PRE)));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ref_done |=> !ref_done);

  assert_grant_starts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && ref_gnt) |=> (strobe_own && !ref_req));

  assert_pending_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pend_cnt <= PEND_W'(MAX_PEND));

  assert_quiet_strobes_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_own |-> (ras_n && cas_n && we_n));

  assert_row_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n && !$past(ras_n)) |-> $stable(row_addr));

  generate
    if (RAS_ONLY) begin : g_ro_checks
      assert_cas_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> cas_n);
    end else begin : g_cbr_checks
      assert_cas_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (!cas_n && !$past(cas_n) && we_n && $past(we_n)));
    end
  endgenerate
endmodule

bind dram_refresh_seq dram_refresh_chk #(
  .RAS_ONLY(RAS_ONLY),
  .ROW_W   (ROW_W),
  .PEND_W  (PEND_W),
  .MAX_PEND(MAX_PEND),
  .L_ACT   (L_ACT),
  .L_PRE   (L_PRE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ref_gnt   (ref_gnt),
  .ref_req   (ref_req),
  .ref_done  (ref_done),
  .init_done (init_done),
  .strobe_own(strobe_own),
  .ras_n     (ras_n),
  .cas_n     (cas_n),
  .we_n      (we_n),
  .row_addr  (row_addr),
  .pend_cnt  (pend_cnt)
);

// File: tb/dram_refresh_seq_tb.sv
module dram_refresh_seq_tb;
  localparam int PERIOD_PS = 8000;
  localparam int PU_NS     = 2001;
  localparam int IV_NS     = 797;
  localparam int MAXP      = 3;
  localparam int NINIT     = 8;

  function automatic int cyc(input int ns);
    int c;
    c = ns * 1000 / PERIOD_PS;
    if (c * PERIOD_PS < ns * 1000) c = c + 1;
    return c;
  endfunction

  localparam int PU = (PU_NS * 1000 + PERIOD_PS - 1) / PERIOD_PS;  // 251
  localparam int IV = (IV_NS * 1000 + PERIOD_PS - 1) / PERIOD_PS;  // 100

  // expected {own, ras_n, cas_n, we_n, ref_done} per cycle of a granted refresh
  // (1 lead, 8 RAS low with CAS low for 2, 5 precharge) R5 R6 R7 R11
  localparam logic [4:0] SHAPE [14] = '{
    5'b11010, 5'b10010, 5'b10010, 5'b10110, 5'b10110, 5'b10110, 5'b10110,
    5'b10110, 5'b10110, 5'b11110, 5'b11110, 5'b11110, 5'b11110, 5'b11111};

  logic clk = 1'b0;
  logic rst_n;
  logic gnt, req, done, ready, own, ras, cas, we;
  logic [10:0] addr;
  logic gnt_ro, req_ro, done_ro, ready_ro, own_ro, ras_ro, cas_ro, we_ro;
  logic [2:0] addr_ro;

  int n_chk = 0;
  int n_fail = 0;
  int tr = 0;
  int wd = 0;

  always #4 clk = ~clk;

  dram_refresh_seq #(
    .CLK_PERIOD_PS(PERIOD_PS), .POWERUP_NS(PU_NS), .INIT_CYCLES(NINIT),
    .INTERVAL_NS(IV_NS), .MAX_PEND(MAXP)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_gnt(gnt), .ref_req(req), .ref_done(done),
    .init_done(ready), .strobe_own(own), .ras_n(ras), .cas_n(cas), .we_n(we),
    .row_addr(addr)
  );

  dram_refresh_seq #(
    .CLK_PERIOD_PS(PERIOD_PS), .ROW_W(3), .RAS_ONLY(1'b1), .POWERUP_NS(PU_NS),
    .INIT_CYCLES(NINIT), .INTERVAL_NS(IV_NS), .MAX_PEND(MAXP)
  ) u_dut_ro (
    .clk(clk), .rst_n(rst_n), .ref_gnt(gnt_ro), .ref_req(req_ro), .ref_done(done_ro),
    .init_done(ready_ro), .strobe_own(own_ro), .ras_n(ras_ro), .cas_n(cas_ro),
    .we_n(we_ro), .row_addr(addr_ro)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic adv();
    @(negedge clk);
    tr++;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd == 100000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  // RAS-only instance: row address sequence, wrap and stability (R10)
  logic ro_prev = 1'b1;
  int   exp_row = 0;
  int   fall_addr = 0;
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (ro_prev && !ras_ro) begin
        chk("R10 row address at RAS fall (wraps mod 8)", int'(addr_ro), exp_row);
        chk("R10 CAS high in RAS-only cycle", int'(cas_ro), 1);
        fall_addr = int'(addr_ro);
        exp_row = (exp_row + 1) % 8;
      end else if (!ro_prev && ras_ro) begin
        chk("R10 row address held through RAS low", int'(addr_ro), fall_addr);
      end
      ro_prev = ras_ro;
    end
  end

  initial begin
    int bad;
    int falls;
    int reqs;
    int dones;
    logic prev;
    rst_n = 1'b0;
    gnt = 1'b0;
    gnt_ro = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 strobes in reset", int'({ras, cas, we}), 7);
    chk("R1 req/done/ready/own in reset", int'({req, done, ready, own}), 0);
    rst_n = 1'b1;

    // R2 quiet power-up, R11 rounding (2001 ns -> 251 cycles)
    chk("R11 power-up cycle count", cyc(PU_NS), PU);
    bad = 0;
    for (int k = 1; k <= PU; k++) begin
      @(negedge clk);
      if (own || !ras || !cas || ready) bad++;
    end
    chk("R2 no activity during power-up", bad, 0);
    @(negedge clk);
    chk("R11 first init cycle right after rounded wait", int'(own), 1);

    // R3 init cycles without grant
    falls = 0;
    reqs = 0;
    prev = ras;
    while (!ready) begin
      @(negedge clk);
      if (prev && !ras) falls++;
      prev = ras;
      if (req) reqs++;
    end
    chk("R3 init refresh count", falls, NINIT);
    chk("R3 no request before ready", reqs, 0);

    // R4 interval (797 ns -> 100 cycles, R11)
    tr = 0;
    while (tr < IV - 1) adv();
    chk("R4 no request before interval", int'(req), 0);
    adv();
    chk("R4 R11 request after rounded interval", int'(req), 1);

    // vector walk of a granted CAS-before-RAS cycle
    gnt = 1'b1;
    for (int i = 0; i < 14; i++) begin
      adv();
      if (i == 0) begin
        chk("R7 request drops once cycle starts", int'(req), 0);
        gnt = 1'b0;
      end
      chk($sformatf("R5 R6 R7 cycle shape step %0d", i),
          int'({own, ras, cas, we, done}), int'(SHAPE[i]));
    end
    adv();
    chk("R12 strobes released after cycle", int'({own, ras, cas, we, done}), 5'b01110);

    // R8 saturation: six ticks elapse without grant
    while (tr < 705) adv();
    gnt = 1'b1;
    dones = 0;
    while (tr < 765) begin
      adv();
      if (done) dones++;
    end
    chk("R8 serviced refreshes after saturation", dones, MAXP);
    chk("R8 request clear after backlog drained", int'(req), 0);

    // R9 grant without request is ignored
    bad = 0;
    while (tr < 795) begin
      adv();
      if (own || done || !ras || !cas) bad++;
    end
    chk("R9 grant without request ignored", bad, 0);
    gnt = 1'b0;
    while (tr < 8 * IV) adv();
    chk("R4 next interval request", int'(req), 1);

    finish_run();
  end
endmodule